// File: doc/BRIEF.md
# Paravirtual Device Interrupt Status Controller

This block keeps the interrupt status byte of a paravirtual PCI function and drives that function's two interrupt outputs. A queue-event pulse and a configuration-change pulse come in from the device core. An MSI-X enable level selects how the driver is told about them: through the level-sensitive legacy INTx line, or through a one-cycle message request that carries an MSI-X table entry number.

The driver reads the status byte through a one-cycle read strobe. The read returns the byte, clears it in the same operation and so drops INTx. A configuration change always records its flag, in both modes, so that the driver does not have to scan configuration space to find out what changed. A queue event records its flag only in legacy mode. In MSI-X mode a queue event leaves the byte alone and raises a message request instead.

The message request has no back-pressure: it is a pulse that lasts one cycle and is never held. When a configuration message and a queue message fall due in the same cycle, the configuration message goes out first. The queue message waits in a one-entry holding slot and goes out in the next free cycle. Further queue events that arrive while the slot is full merge into it.

Top module: `isr_irq_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, `intx_o` is low, `msg_req_o` is low and `rd_data_o` reads 0x00.
- R2: A cycle with `rd_en_i` high loads the current status byte into `rd_data_o` at that clock edge and clears the status. With no event in that cycle, the status is 0x00 afterwards and `intx_o` is low.
- R3: A `cfg_evt_i` pulse sets status bit 1 (value 0x02) at the next edge. This happens whether MSI-X is enabled or disabled.
- R4: A `queue_evt_i` pulse sets status bit 0 (value 0x01) only when `msix_en_i` is low.
- R5: `intx_o` is high exactly when `msix_en_i` is low and the status byte is non-zero. Raising `msix_en_i` forces it low, and lowering it again restores it without any edge in between.
- R6: With MSI-X enabled, a configuration event whose `cfg_vec_i` is not NO_VECTOR produces `msg_req_o` high for exactly one cycle, starting after the next edge, with `msg_vec_o` equal to that vector.
- R7: With MSI-X enabled, a queue event whose `queue_vec_i` is not NO_VECTOR produces a one-cycle message request carrying the queue vector. The status byte is not changed.
- R8: NO_VECTOR is 16'hFFFF. An event whose vector equals NO_VECTOR produces no message request.
- R9: An event that arrives in the same cycle as a read is not lost. Its bit is present after the clear and is returned by the next read.
- R10: Status bits 7 to 2 always read as zero.
- R11: When configuration and queue messages are both due in the same cycle, the configuration message goes out first. The queue message follows in the next cycle.
- R12: With MSI-X disabled, `msg_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queue_evt_i | input | 1 | One-cycle queue event pulse |
| cfg_evt_i | input | 1 | One-cycle configuration-change pulse |
| msix_en_i | input | 1 | MSI-X enabled level |
| cfg_vec_i | input | 16 | Table entry used for configuration messages |
| queue_vec_i | input | 16 | Table entry used for queue messages |
| rd_en_i | input | 1 | Status read strobe (read and clear) |
| rd_data_o | output | 8 | Status byte captured by the last read |
| intx_o | output | 1 | Legacy level interrupt |
| msg_req_o | output | 1 | One-cycle message request |
| msg_vec_o | output | 16 | Table entry of the current request |

## Verification
The bench builds the block with its default parameters: an 8-bit status byte and 16-bit vectors, so NO_VECTOR is 16'hFFFF. These widths put the real all-ones vector within reach, so it can be tested against ordinary entry numbers. They also keep the reserved upper bits of the byte visible on every read. A scoreboard holds the expected message vectors in order. It therefore catches a message that goes out when none is due, a pulse longer than one cycle, and configuration and queue messages issued in the wrong order when they collide.

// File: rtl/virtio_isr_pkg.sv
package virtio_isr_pkg;
  localparam int unsigned ISR_W     = 8;
  localparam int unsigned QUEUE_BIT = 0;
  localparam int unsigned CFG_BIT   = 1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CFG   = 2'd1,
    SRC_QUEUE = 2'd2
  } msg_src_e;
endpackage

// File: rtl/isr_status_reg.sv
module isr_status_reg
  import virtio_isr_pkg::*;
#(
  parameter int unsigned W = ISR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_queue,
  input  logic         set_cfg,
  input  logic         rd_en,
  output logic [W-1:0] status,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] set_mask;
  logic [W-1:0] status_nxt;

  always_comb begin
    set_mask            = '0;
    set_mask[QUEUE_BIT] = set_queue;
    set_mask[CFG_BIT]   = set_cfg;
    // clear from the read applies first, new events land on top
    status_nxt = (rd_en ? '0 : status) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      rd_data <= '0;
    end else begin
      status <= status_nxt;
      if (rd_en) rd_data <= status;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[W-1:2] == '0); // R10
  AST_CFG_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    set_cfg |=> status[CFG_BIT]); // R3
  AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && set_queue) |=> status[QUEUE_BIT]); // R9
endmodule

// File: rtl/isr_intx_drv.sv
module isr_intx_drv
  import virtio_isr_pkg::*;
#(
  parameter int unsigned W = ISR_W
) (
  input  logic         msix_en,
  input  logic [W-1:0] status,
  output logic         intx
);
  always_comb intx = !msix_en && (status != '0);
endmodule

// File: rtl/isr_msg_sched.sv
module isr_msg_sched
  import virtio_isr_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msix_en,
  input  logic             cfg_evt,
  input  logic             queue_evt,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic [VEC_W-1:0] queue_vec,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec
);
  localparam logic [VEC_W-1:0] NO_VEC = '1;

  logic             cfg_new, q_new, q_any;
  logic             q_pend;
  logic [VEC_W-1:0] q_hold, q_sel;
  msg_src_e         src;

  always_comb begin
    cfg_new = msix_en && cfg_evt && (cfg_vec != NO_VEC);
    q_new   = msix_en && queue_evt && (queue_vec != NO_VEC);
    q_any   = q_new || (q_pend && msix_en);
    q_sel   = q_new ? queue_vec : q_hold;
    if (cfg_new)    src = SRC_CFG;
    else if (q_any) src = SRC_QUEUE;
    else            src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_req <= 1'b0;
      msg_vec <= '0;
      q_pend  <= 1'b0;
      q_hold  <= '0;
    end else begin
      unique case (src)
        SRC_CFG: begin
          msg_req <= 1'b1;
          msg_vec <= cfg_vec;
          q_pend  <= q_any;
          q_hold  <= q_sel;
        end
        SRC_QUEUE: begin
          msg_req <= 1'b1;
          msg_vec <= q_sel;
          q_pend  <= 1'b0;
        end
        default: begin
          msg_req <= 1'b0;
          q_pend  <= 1'b0;
        end
      endcase
    end
  end

  AST_NO_NOVEC_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msg_vec != NO_VEC)); // R8
  AST_CFG_MSG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_en && cfg_evt && cfg_vec != NO_VEC) |=> (msg_req && msg_vec == $past(cfg_vec))); // R6
  AST_LEGACY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !msix_en |=> !msg_req); // R12
endmodule

// File: rtl/isr_irq_ctrl.sv
module isr_irq_ctrl
  import virtio_isr_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             queue_evt_i,
  input  logic             cfg_evt_i,
  input  logic             msix_en_i,
  input  logic [VEC_W-1:0] cfg_vec_i,
  input  logic [VEC_W-1:0] queue_vec_i,
  input  logic             rd_en_i,
  output logic [ISR_W-1:0] rd_data_o,
  output logic             intx_o,
  output logic             msg_req_o,
  output logic [VEC_W-1:0] msg_vec_o
);
  logic [ISR_W-1:0] status;
  logic             set_queue;

  // queue flag is recorded only on the legacy path
  assign set_queue = queue_evt_i && !msix_en_i;

  isr_status_reg #(.W(ISR_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_queue(set_queue), .set_cfg(cfg_evt_i), .rd_en(rd_en_i),
    .status(status), .rd_data(rd_data_o)
  );

  isr_intx_drv #(.W(ISR_W)) u_intx (
    .msix_en(msix_en_i), .status(status), .intx(intx_o)
  );

  isr_msg_sched #(.VEC_W(VEC_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en_i),
    .cfg_evt(cfg_evt_i), .queue_evt(queue_evt_i),
    .cfg_vec(cfg_vec_i), .queue_vec(queue_vec_i),
    .msg_req(msg_req_o), .msg_vec(msg_vec_o)
  );

  AST_READ_DROPS_INTX: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !cfg_evt_i && !(queue_evt_i && !msix_en_i)) |=> !intx_o); // R2
  AST_QUEUE_MSIX_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_en_i && rd_en_i && !cfg_evt_i) |=> (status == '0)); // R7
endmodule

// File: tb/sim_isr_irq_ctrl.sv
`timescale 1ns/1ps
module sim_isr_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        queue_evt_i = 1'b0, cfg_evt_i = 1'b0, msix_en_i = 1'b0, rd_en_i = 1'b0;
  logic [15:0] cfg_vec_i = '0, queue_vec_i = '0;
  logic [7:0]  rd_data_o;
  logic        intx_o, msg_req_o;
  logic [15:0] msg_vec_o;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  isr_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .queue_evt_i(queue_evt_i), .cfg_evt_i(cfg_evt_i),
    .msix_en_i(msix_en_i), .cfg_vec_i(cfg_vec_i), .queue_vec_i(queue_vec_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .intx_o(intx_o),
    .msg_req_o(msg_req_o), .msg_vec_o(msg_vec_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every request must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && msg_req_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R12 unexpected message actual=%0h expected=none", msg_vec_o);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (msg_vec_o !== e) begin
          n_bad++;
          $display("FAIL R11 message vector actual=%0h expected=%0h", msg_vec_o, e);
        end
      end
    end
  end

  // inputs change just after a falling edge and are held for one cycle
  task automatic pulse(input logic q, input logic c, input logic rd);
    queue_evt_i = q; cfg_evt_i = c; rd_en_i = rd;
    if (msix_en_i && c && cfg_vec_i != 16'hFFFF) exp_q.push_back(cfg_vec_i);
    if (msix_en_i && q && queue_vec_i != 16'hFFFF) exp_q.push_back(queue_vec_i);
    @(negedge clk);
    queue_evt_i = 1'b0; cfg_evt_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] exp);
    pulse(1'b0, 1'b0, 1'b1);
    check(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 intx", intx_o, 0);
    check("R1 msg", msg_req_o, 0);
    check("R1 rd_data", rd_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check("R1 status after reset", 8'h00);

    // legacy configuration change
    pulse(1'b0, 1'b1, 1'b0);
    check("R5 intx legacy cfg", intx_o, 1);
    rd_check("R3 cfg bit legacy", 8'h02);
    check("R2 intx after read", intx_o, 0);
    rd_check("R2 cleared by read", 8'h00);

    // legacy queue event, no message expected (R12)
    queue_vec_i = 16'h0004;
    pulse(1'b1, 1'b0, 1'b0);
    check("R4 intx legacy queue", intx_o, 1);
    check("R12 no msg legacy", msg_req_o, 0);
    rd_check("R4 queue bit legacy", 8'h01);

    // event in the same cycle as a read
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    check("R9 read returns old byte", rd_data_o, 8'h02);
    check("R9 intx still up", intx_o, 1);
    rd_check("R9 event kept", 8'h01);

    // both bits, reserved bits zero
    pulse(1'b1, 1'b1, 1'b0);
    rd_check("R10 both bits, upper zero", 8'h03);

    // MSI-X queue event
    msix_en_i = 1'b1;
    queue_vec_i = 16'h0005;
    pulse(1'b1, 1'b0, 1'b0);
    check("R7 msg pulse queue", msg_req_o, 1);
    check("R7 intx low", intx_o, 0);
    @(negedge clk);
    check("R6 one-cycle pulse", msg_req_o, 0);
    rd_check("R7 status untouched", 8'h00);

    // MSI-X config event
    cfg_vec_i = 16'h0003;
    pulse(1'b0, 1'b1, 1'b0);
    check("R6 msg vec cfg", msg_vec_o, 16'h0003);
    check("R5 intx low in msix", intx_o, 0);
    @(negedge clk);
    rd_check("R3 cfg bit msix", 8'h02);

    // NO_VECTOR
    cfg_vec_i = 16'hFFFF;
    queue_vec_i = 16'hFFFF;
    pulse(1'b1, 1'b1, 1'b0);
    check("R8 no msg on NO_VECTOR", msg_req_o, 0);
    rd_check("R8 cfg bit still set", 8'h02);

    // collision: cfg first, queue next
    cfg_vec_i = 16'h0007;
    queue_vec_i = 16'h0009;
    pulse(1'b1, 1'b1, 1'b0);
    check("R11 cfg first", msg_vec_o, 16'h0007);
    @(negedge clk);
    check("R11 queue second req", msg_req_o, 1);
    check("R11 queue second vec", msg_vec_o, 16'h0009);
    @(negedge clk);
    check("R11 then idle", msg_req_o, 0);
    rd_check("R3 cfg bit after collision", 8'h02);

    // enable toggling masks INTx
    msix_en_i = 1'b0;
    pulse(1'b0, 1'b1, 1'b0);
    check("R5 intx up", intx_o, 1);
    msix_en_i = 1'b1; #1;
    check("R5 msix forces low", intx_o, 0);
    msix_en_i = 1'b0; #1;
    check("R5 intx restored", intx_o, 1);
    @(negedge clk);
    rd_check("R2 clear", 8'h02);
    check("R2 intx dropped", intx_o, 0);

    repeat (3) @(negedge clk);
    check("R6 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule